// File: doc/BRIEF.md
# Shared-Cache Line Coherence Controller

This block tracks the coherence state of one line held in an inclusive shared second-level cache bank. The bank sits behind a set of private first-level caches and in front of memory. A decoder upstream turns incoming messages into event codes and presents them one at a time. Each event carries the index of the first-level cache that sent or requested it and a dirty qualifier.

For each accepted event the controller picks the next state and raises one-cycle action strobes in the same cycle as the event. The strobes cover memory fetch, forwarding to the owner, data responses, invalidations, transaction-entry allocate and free, recycle, writeback acknowledge and memory writeback. Destination masks tell the message layer which caches each response or request goes to.

The controller keeps the sharer set, the owner index and the reader set of a pending fill. It also counts the invalidation acknowledges still owed during an eviction. The data array, the tag lookup and message transport belong to the surrounding logic.

Top module: `coh_line_fsm`

## Requirements
- R1: After reset `o_state` is 0, `o_err` is 0, `o_sharers` is empty and every strobe is low. The state codes are: 0 absent, 1 shared, 2 modified-in-bank, 3 owned-by-L1, 4 single-reader fill, 5 multi-reader fill, 6 exclusive fill, 7 blocked-from-shared, 8 blocked-for-owner, 9 read-wait-both, 10 read-wait-data, 11 read-wait-unblock, 12 shared-evict-clean, 13 shared-evict-dirty, 14 owner-evict-dirty, 15 owner-evict-clean, 16 memory-writeback-wait.
- R2: In state 0, each read type raises `o_fetch` and `o_tbe_alloc` and selects a fill state. A data read (code 0) selects state 4. An instruction read (code 1) selects state 5. An exclusive read (code 2) selects state 6.
- R3: In states 4 and 5, a further data or instruction read moves the line to state 5 and adds the requester to the reader set, with no strobe. An exclusive read there raises only `o_recycle`.
- R4: Memory data (code 6) completes a fill and raises `o_tbe_free` together with a data strobe.
  - From state 4, exclusive data goes to the single reader and the line enters state 8.
  - From state 5, shared data goes to every recorded reader (`o_rsp_dst`) and the line enters state 1.
  - From state 6, data goes to the writer and the line enters state 8.
- R5: In states 7 to 11, every read, exclusive read, upgrade (code 3) and replacement (code 5) raises only `o_recycle` and leaves the state unchanged. An exclusive unblock (code 11) in state 7 or 8 moves the line to state 3 and makes the sender both the owner and the only sharer.
- R6: A data or instruction read in state 3 raises `o_fwd`, with `o_req_dst` set to the owner, and enters state 9. An unblock (code 10) and L1 data (code 8) may then arrive in either order: unblock first passes through state 10, data first passes through state 11. Both orders end in state 1 with the reader added to the sharers.
- R7: A replacement in state 1 raises `o_inv` to all sharers and `o_tbe_alloc`. An L1 ack (code 9) that is not the last one raises nothing. On the last ack, a clean eviction (state 12) frees the entry and enters state 0. A dirty eviction (state 13) raises `o_mem_wb` and enters state 16. Memory ack (code 7) in state 16 frees the entry and enters state 0.
- R8: A replacement in state 3 invalidates the owner and enters state 14 if `evt_dirty` is set, otherwise state 15. Dirty L1 data then raises `o_mem_wb` and enters state 16. Clean L1 data frees the entry and enters state 0.
- R9: A writeback (code 4) from the owner in state 3 raises `o_wb_ack` to that owner, clears the sharers and enters state 2. A writeback from a cache that is not a sharer raises no strobe and leaves the state unchanged.
- R10: In state 1:
  - A data read sends shared data to the requester and adds it to the sharers.
  - An exclusive read sends data to the requester, invalidates the other sharers and enters state 7.
  - An upgrade from a sharer raises `o_inv` to the other sharers plus `o_upg_ack` to the upgrader, and enters state 7.
- R11: With `evt_valid` low no strobe rises. Codes 12 to 15, and any event not listed for the current state, set the sticky `o_err`, raise no strobe and leave the state unchanged.
- R12: In state 2:
  - A data read sends exclusive data and enters state 8.
  - An instruction read sends data, adds the reader and enters state 1.
  - A replacement raises `o_mem_wb` and `o_tbe_alloc` and enters state 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An event is presented this cycle |
| evt_code | input | 4 | Event code (see requirements) |
| evt_src | input | ID_W | Requesting or sending first-level cache |
| evt_dirty | input | 1 | Dirty qualifier for replacement and L1 data |
| o_fetch | output | 1 | Issue memory fetch |
| o_fwd | output | 1 | Forward request to the owner |
| o_inv | output | 1 | Send invalidation to `o_req_dst` |
| o_data | output | 1 | Send data to `o_rsp_dst` |
| o_data_excl | output | 1 | The data sent is exclusive |
| o_upg_ack | output | 1 | Acknowledge an upgrade |
| o_wb_ack | output | 1 | Acknowledge an L1 writeback |
| o_mem_wb | output | 1 | Write the line back to memory |
| o_tbe_alloc | output | 1 | Allocate a transaction entry |
| o_tbe_free | output | 1 | Free the transaction entry |
| o_recycle | output | 1 | Put the request back on its queue |
| o_rsp_dst | output | N_L1 | Destination mask of responses |
| o_req_dst | output | N_L1 | Destination mask of forwards and invalidations |
| o_state | output | 5 | Current state code |
| o_sharers | output | N_L1 | Sharer set |
| o_owner | output | ID_W | Owner or recorded writer index |
| o_err | output | 1 | Sticky protocol error |

## Verification
The assertions assume that acks never outnumber the invalidations sent and that a replacement of a shared line always sees at least one sharer. They also assume the dirty qualifier is only meaningful on replacement and L1 data events. The directed stimulus follows legal message orders from the first-level caches and memory, with one ack per invalidated sharer. It breaks these rules only in the final error scenario, which runs after the other checks so that the sticky flag cannot mask them.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

   typedef enum logic [4:0] {
      ST_NONE      = 5'd0,
      ST_SHR       = 5'd1,
      ST_MOD       = 5'd2,
      ST_OWN       = 5'd3,
      ST_FILL_ONE  = 5'd4,
      ST_FILL_MANY = 5'd5,
      ST_FILL_X    = 5'd6,
      ST_BLK_SHR   = 5'd7,
      ST_BLK_OWN   = 5'd8,
      ST_RD_WAIT2  = 5'd9,
      ST_RD_WAITD  = 5'd10,
      ST_RD_WAITU  = 5'd11,
      ST_EVS_CLEAN = 5'd12,
      ST_EVS_DIRTY = 5'd13,
      ST_EVO_DIRTY = 5'd14,
      ST_EVO_CLEAN = 5'd15,
      ST_WB_MEM    = 5'd16
   } cl_state_e;

   localparam logic [3:0] EV_RD      = 4'd0;
   localparam logic [3:0] EV_IRD     = 4'd1;
   localparam logic [3:0] EV_XRD     = 4'd2;
   localparam logic [3:0] EV_UPG     = 4'd3;
   localparam logic [3:0] EV_WB      = 4'd4;
   localparam logic [3:0] EV_REPL    = 4'd5;
   localparam logic [3:0] EV_MDATA   = 4'd6;
   localparam logic [3:0] EV_MACK    = 4'd7;
   localparam logic [3:0] EV_LDATA   = 4'd8;
   localparam logic [3:0] EV_LACK    = 4'd9;
   localparam logic [3:0] EV_UNBLK   = 4'd10;
   localparam logic [3:0] EV_XUNBLK  = 4'd11;

   typedef struct packed {
      logic fetch;
      logic fwd;
      logic inv;
      logic inv_skip_src;
      logic data;
      logic data_excl;
      logic data_rdrs;
      logic data_own;
      logic upg_ack;
      logic wb_ack;
      logic mem_wb;
      logic tbe_alloc;
      logic tbe_free;
      logic recycle;
      logic ack_dec;
      logic sh_add;
      logic sh_clear;
      logic own_set;
      logic rd_add;
      logic rd_clear;
      logic illegal;
   } cl_act_t;

endpackage

// File: rtl/coh_line_sharers.sv
module coh_line_sharers #(
   parameter int N_L1 = 4,
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ID_W-1:0] src,
   input  logic            sh_add,
   input  logic            sh_clear,
   input  logic            own_set,
   input  logic            rd_add,
   input  logic            rd_clear,
   output logic [N_L1-1:0] sharers,
   output logic [N_L1-1:0] readers,
   output logic [ID_W-1:0] owner,
   output logic            src_is_shr
);
   logic [N_L1-1:0] src_oh;
   logic [N_L1-1:0] sh_nx;
   logic [N_L1-1:0] rd_nx;

   always_comb begin
      src_oh = '0;
      src_oh[src] = 1'b1;
      sh_nx = (sh_clear ? '0 : sharers) | (sh_add ? src_oh : '0);
      rd_nx = (rd_clear ? '0 : readers) | (rd_add ? src_oh : '0);
   end

   assign src_is_shr = sharers[src];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sharers <= '0;
         readers <= '0;
         owner   <= '0;
      end else begin
         sharers <= sh_nx;
         readers <= rd_nx;
         if (own_set) owner <= src;
      end
   end
endmodule

// File: rtl/coh_line_ackctr.sv
module coh_line_ackctr #(
   parameter int N_L1 = 4,
   parameter int CW   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [N_L1-1:0] sharers,
   input  logic            dec,
   output logic            last,
   output logic            none
);
   logic [CW-1:0] psum [N_L1+1];
   logic [CW-1:0] pend;

   assign psum[0] = '0;
   for (genvar i = 0; i < N_L1; i++) begin : g_pop
      assign psum[i+1] = psum[i] + CW'(sharers[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pend <= '0;
      else if (load) pend <= psum[N_L1];
      else if (dec)  pend <= pend - 1'b1;
   end

   assign last = (pend == CW'(1));
   assign none = (pend == '0);
endmodule

// File: rtl/coh_line_decode.sv
module coh_line_decode
   import coh_line_pkg::*;
(
   input  logic      valid,
   input  logic [3:0] ev,
   input  cl_state_e st,
   input  logic      src_shr,
   input  logic      dirty,
   input  logic      ack_last,
   input  logic      ack_none,
   output cl_state_e nxt,
   output cl_act_t   a
);
   logic is_rd, is_x, is_upg, is_req, is_repl;

   always_comb begin
      is_rd   = (ev == EV_RD) || (ev == EV_IRD);
      is_x    = (ev == EV_XRD) || ((ev == EV_UPG) && !src_shr);
      is_upg  = (ev == EV_UPG) && src_shr;
      is_req  = is_rd || is_x || is_upg;
      is_repl = (ev == EV_REPL);
   end

   always_comb begin
      nxt = st;
      a   = '0;
      if (!valid) begin
         a = '0;
      end else if (ev == EV_WB) begin
         if (src_shr && st == ST_OWN) begin
            nxt        = ST_MOD;
            a.wb_ack   = 1'b1;
            a.sh_clear = 1'b1;
         end else if (src_shr && st == ST_BLK_OWN) begin
            a.recycle = 1'b1;
         end
      end else begin
         unique case (st)
            ST_NONE: begin
               if (is_rd) begin
                  nxt         = (ev == EV_RD) ? ST_FILL_ONE : ST_FILL_MANY;
                  a.fetch     = 1'b1;
                  a.tbe_alloc = 1'b1;
                  a.sh_clear  = 1'b1;
                  a.sh_add    = 1'b1;
                  a.rd_clear  = 1'b1;
                  a.rd_add    = 1'b1;
               end else if (is_x) begin
                  nxt         = ST_FILL_X;
                  a.fetch     = 1'b1;
                  a.tbe_alloc = 1'b1;
                  a.sh_clear  = 1'b1;
                  a.own_set   = 1'b1;
                  a.rd_clear  = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_FILL_ONE, ST_FILL_MANY: begin
               if (is_rd) begin
                  nxt      = ST_FILL_MANY;
                  a.sh_add = 1'b1;
                  a.rd_add = 1'b1;
               end else if (is_x || is_upg || is_repl) begin
                  a.recycle = 1'b1;
               end else if (ev == EV_MDATA) begin
                  nxt         = (st == ST_FILL_ONE) ? ST_BLK_OWN : ST_SHR;
                  a.data_rdrs = 1'b1;
                  a.data_excl = (st == ST_FILL_ONE);
                  a.tbe_free  = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_FILL_X: begin
               if (is_req || is_repl) a.recycle = 1'b1;
               else if (ev == EV_MDATA) begin
                  nxt        = ST_BLK_OWN;
                  a.data_own = 1'b1;
                  a.tbe_free = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_SHR: begin
               if (is_rd) begin
                  a.data   = 1'b1;
                  a.sh_add = 1'b1;
               end else if (is_x) begin
                  nxt            = ST_BLK_SHR;
                  a.data         = 1'b1;
                  a.inv          = 1'b1;
                  a.inv_skip_src = 1'b1;
               end else if (is_upg) begin
                  nxt            = ST_BLK_SHR;
                  a.inv          = 1'b1;
                  a.inv_skip_src = 1'b1;
                  a.upg_ack      = 1'b1;
               end else if (is_repl) begin
                  nxt         = dirty ? ST_EVS_DIRTY : ST_EVS_CLEAN;
                  a.inv       = 1'b1;
                  a.tbe_alloc = 1'b1;
                  a.sh_clear  = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_MOD: begin
               if (ev == EV_RD) begin
                  nxt         = ST_BLK_OWN;
                  a.data      = 1'b1;
                  a.data_excl = 1'b1;
               end else if (ev == EV_IRD) begin
                  nxt      = ST_SHR;
                  a.data   = 1'b1;
                  a.sh_add = 1'b1;
               end else if (is_x) begin
                  nxt    = ST_BLK_OWN;
                  a.data = 1'b1;
               end else if (is_repl) begin
                  nxt         = ST_WB_MEM;
                  a.mem_wb    = 1'b1;
                  a.tbe_alloc = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_OWN: begin
               if (is_rd) begin
                  nxt   = ST_RD_WAIT2;
                  a.fwd = 1'b1;
               end else if (is_x) begin
                  nxt   = ST_BLK_OWN;
                  a.fwd = 1'b1;
               end else if (is_repl) begin
                  nxt         = dirty ? ST_EVO_DIRTY : ST_EVO_CLEAN;
                  a.inv       = 1'b1;
                  a.tbe_alloc = 1'b1;
                  a.sh_clear  = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_BLK_SHR, ST_BLK_OWN: begin
               if (is_req || is_repl) a.recycle = 1'b1;
               else if (ev == EV_XUNBLK) begin
                  nxt        = ST_OWN;
                  a.sh_clear = 1'b1;
                  a.sh_add   = 1'b1;
                  a.own_set  = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_RD_WAIT2: begin
               if (is_req || is_repl) a.recycle = 1'b1;
               else if (ev == EV_UNBLK) begin
                  nxt      = ST_RD_WAITD;
                  a.sh_add = 1'b1;
               end else if (ev == EV_LDATA) nxt = ST_RD_WAITU;
               else a.illegal = 1'b1;
            end
            ST_RD_WAITD: begin
               if (is_req || is_repl) a.recycle = 1'b1;
               else if (ev == EV_LDATA) nxt = ST_SHR;
               else a.illegal = 1'b1;
            end
            ST_RD_WAITU: begin
               if (is_req || is_repl) a.recycle = 1'b1;
               else if (ev == EV_UNBLK) begin
                  nxt      = ST_SHR;
                  a.sh_add = 1'b1;
               end else a.illegal = 1'b1;
            end
            ST_EVS_CLEAN, ST_EVS_DIRTY, ST_EVO_DIRTY, ST_EVO_CLEAN: begin
               if (is_req) a.recycle = 1'b1;
               else if (ev == EV_LACK && !ack_none) begin
                  a.ack_dec = 1'b1;
                  if (ack_last) begin
                     if (st == ST_EVS_CLEAN || st == ST_EVO_CLEAN) begin
                        nxt        = ST_NONE;
                        a.tbe_free = 1'b1;
                     end else begin
                        nxt      = ST_WB_MEM;
                        a.mem_wb = 1'b1;
                     end
                  end
               end else if (ev == EV_LDATA &&
                            (st == ST_EVO_DIRTY || st == ST_EVO_CLEAN)) begin
                  if (dirty) begin
                     nxt      = ST_WB_MEM;
                     a.mem_wb = 1'b1;
                  end else begin
                     nxt        = ST_NONE;
                     a.tbe_free = 1'b1;
                  end
               end else a.illegal = 1'b1;
            end
            ST_WB_MEM: begin
               if (is_req) a.recycle = 1'b1;
               else if (ev == EV_MACK) begin
                  nxt        = ST_NONE;
                  a.tbe_free = 1'b1;
               end else a.illegal = 1'b1;
            end
            default: a.illegal = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/coh_line_fsm.sv
module coh_line_fsm
   import coh_line_pkg::*;
#(
   parameter int N_L1 = 4,
   localparam int ID_W = (N_L1 > 1) ? $clog2(N_L1) : 1,
   localparam int CW   = $clog2(N_L1 + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_valid,
   input  logic [3:0]      evt_code,
   input  logic [ID_W-1:0] evt_src,
   input  logic            evt_dirty,
   output logic            o_fetch,
   output logic            o_fwd,
   output logic            o_inv,
   output logic            o_data,
   output logic            o_data_excl,
   output logic            o_upg_ack,
   output logic            o_wb_ack,
   output logic            o_mem_wb,
   output logic            o_tbe_alloc,
   output logic            o_tbe_free,
   output logic            o_recycle,
   output logic [N_L1-1:0] o_rsp_dst,
   output logic [N_L1-1:0] o_req_dst,
   output logic [4:0]      o_state,
   output logic [N_L1-1:0] o_sharers,
   output logic [ID_W-1:0] o_owner,
   output logic            o_err
);
   if (N_L1 < 2 || N_L1 > 64) begin : g_bad_n
      $error("coh_line_fsm: N_L1 must lie in 2..64");
   end

   cl_state_e       st, nxt;
   cl_act_t         a;
   logic            err_q;
   logic [N_L1-1:0] sharers, readers, src_oh, own_oh;
   logic [ID_W-1:0] owner;
   logic            src_shr, ack_last, ack_none;

   coh_line_decode u_dec (
      .valid(evt_valid), .ev(evt_code), .st(st), .src_shr(src_shr),
      .dirty(evt_dirty), .ack_last(ack_last), .ack_none(ack_none),
      .nxt(nxt), .a(a)
   );

   coh_line_sharers #(.N_L1(N_L1), .ID_W(ID_W)) u_shr (
      .clk(clk), .rst_n(rst_n), .src(evt_src),
      .sh_add(a.sh_add), .sh_clear(a.sh_clear), .own_set(a.own_set),
      .rd_add(a.rd_add), .rd_clear(a.rd_clear),
      .sharers(sharers), .readers(readers), .owner(owner),
      .src_is_shr(src_shr)
   );

   coh_line_ackctr #(.N_L1(N_L1), .CW(CW)) u_ack (
      .clk(clk), .rst_n(rst_n), .load(a.tbe_alloc), .sharers(sharers),
      .dec(a.ack_dec), .last(ack_last), .none(ack_none)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_NONE;
         err_q <= 1'b0;
      end else begin
         st    <= nxt;
         err_q <= err_q | a.illegal;
      end
   end

   always_comb begin
      src_oh = '0;
      src_oh[evt_src] = 1'b1;
      own_oh = '0;
      own_oh[owner] = 1'b1;
      if (a.data_rdrs)                              o_rsp_dst = readers;
      else if (a.data_own)                          o_rsp_dst = own_oh;
      else if (a.data || a.upg_ack || a.wb_ack)     o_rsp_dst = src_oh;
      else                                          o_rsp_dst = '0;
      if (a.fwd)      o_req_dst = own_oh;
      else if (a.inv) o_req_dst = sharers & ~(a.inv_skip_src ? src_oh : '0);
      else            o_req_dst = '0;
   end

   assign o_fetch     = a.fetch;
   assign o_fwd       = a.fwd;
   assign o_inv       = a.inv;
   assign o_data      = a.data | a.data_rdrs | a.data_own;
   assign o_data_excl = a.data_excl;
   assign o_upg_ack   = a.upg_ack;
   assign o_wb_ack    = a.wb_ack;
   assign o_mem_wb    = a.mem_wb;
   assign o_tbe_alloc = a.tbe_alloc;
   assign o_tbe_free  = a.tbe_free;
   assign o_recycle   = a.recycle;
   assign o_state     = st;
   assign o_sharers   = sharers;
   assign o_owner     = owner;
   assign o_err       = err_q;
endmodule

// File: rtl/coh_line_chk.sv
module coh_line_chk #(
   parameter int N_L1 = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            evt_valid,
   input logic [3:0]      evt_code,
   input logic            o_fetch,
   input logic            o_fwd,
   input logic            o_inv,
   input logic            o_data,
   input logic            o_upg_ack,
   input logic            o_wb_ack,
   input logic            o_mem_wb,
   input logic            o_tbe_alloc,
   input logic            o_tbe_free,
   input logic            o_recycle,
   input logic [4:0]      o_state,
   input logic [N_L1-1:0] o_sharers,
   input logic            o_err
);
   // R1
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_state <= 5'd16);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |-> !(o_fetch | o_fwd | o_inv | o_data | o_upg_ack |
                       o_wb_ack | o_mem_wb | o_tbe_alloc | o_tbe_free | o_recycle));

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |=> o_err);

   // R5
   recycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_recycle |=> $stable(o_state));

   // R2
   fetch_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_fetch |=> (o_state == 5'd4 || o_state == 5'd5 || o_state == 5'd6));

   // R5
   xunblk_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 4'd11 && (o_state == 5'd7 || o_state == 5'd8))
      |=> (o_state == 5'd3 && $onehot(o_sharers)));

   // R7
   free_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_tbe_free |=> (o_state == 5'd0 || o_state == 5'd1 || o_state == 5'd8));

   // R4
   excl_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({o_fetch, o_fwd, o_mem_wb, o_recycle}));
endmodule

bind coh_line_fsm coh_line_chk #(.N_L1(N_L1)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
   .o_fetch(o_fetch), .o_fwd(o_fwd), .o_inv(o_inv), .o_data(o_data),
   .o_upg_ack(o_upg_ack), .o_wb_ack(o_wb_ack), .o_mem_wb(o_mem_wb),
   .o_tbe_alloc(o_tbe_alloc), .o_tbe_free(o_tbe_free), .o_recycle(o_recycle),
   .o_state(o_state), .o_sharers(o_sharers), .o_err(o_err)
);

// File: tb/sim_coh_line_fsm.sv
module sim_coh_line_fsm;
   localparam int CLK_P = 10;
   localparam int N = 4;

   localparam logic [3:0] E_RD = 0, E_IRD = 1, E_XRD = 2, E_UPG = 3, E_WB = 4,
      E_REPL = 5, E_MDATA = 6, E_MACK = 7, E_LDATA = 8, E_LACK = 9,
      E_UNBLK = 10, E_XUNBLK = 11;

   localparam logic [10:0] S_FETCH = 11'h400, S_FWD = 11'h200, S_INV = 11'h100,
      S_DATA = 11'h080, S_EXCL = 11'h040, S_UPGA = 11'h020, S_WBA = 11'h010,
      S_MWB = 11'h008, S_ALLOC = 11'h004, S_FREE = 11'h002, S_RCY = 11'h001,
      S_NONE = 11'h000;

   logic clk = 0, rst_n = 0, evt_valid = 0, evt_dirty = 0;
   logic [3:0] evt_code = '0;
   logic [1:0] evt_src = '0;
   logic o_fetch, o_fwd, o_inv, o_data, o_data_excl, o_upg_ack, o_wb_ack;
   logic o_mem_wb, o_tbe_alloc, o_tbe_free, o_recycle, o_err;
   logic [N-1:0] o_rsp_dst, o_req_dst, o_sharers;
   logic [4:0] o_state;
   logic [1:0] o_owner;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [10:0] cap;
   logic [N-1:0] cap_rsp, cap_req;

   always #(CLK_P/2) clk = ~clk;

   coh_line_fsm #(.N_L1(N)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_src(evt_src), .evt_dirty(evt_dirty),
      .o_fetch(o_fetch), .o_fwd(o_fwd), .o_inv(o_inv), .o_data(o_data),
      .o_data_excl(o_data_excl), .o_upg_ack(o_upg_ack), .o_wb_ack(o_wb_ack),
      .o_mem_wb(o_mem_wb), .o_tbe_alloc(o_tbe_alloc), .o_tbe_free(o_tbe_free),
      .o_recycle(o_recycle), .o_rsp_dst(o_rsp_dst), .o_req_dst(o_req_dst),
      .o_state(o_state), .o_sharers(o_sharers), .o_owner(o_owner), .o_err(o_err)
   );

   task automatic chk(input string r, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   function automatic logic [10:0] strobes();
      return {o_fetch, o_fwd, o_inv, o_data, o_data_excl, o_upg_ack,
              o_wb_ack, o_mem_wb, o_tbe_alloc, o_tbe_free, o_recycle};
   endfunction

   // drive on negedge, capture strobes mid-cycle, release after the edge
   task automatic step(input string r, input logic [3:0] c, input int s,
                       input logic d, input logic [10:0] exp_s,
                       input logic [4:0] exp_st);
      @(negedge clk);
      evt_valid = 1; evt_code = c; evt_src = s[1:0]; evt_dirty = d;
      #1;
      cap = strobes(); cap_rsp = o_rsp_dst; cap_req = o_req_dst;
      @(posedge clk); #1;
      evt_valid = 0;
      chk(r, "strobes", 32'(cap), 32'(exp_s));
      chk(r, "state", 32'(o_state), 32'(exp_st));
   endtask

   task automatic do_reset();
      evt_valid = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk); #1;
      chk("R1", "state", 32'(o_state), 0);
      chk("R1", "err", 32'(o_err), 0);
      chk("R1", "sharers", 32'(o_sharers), 0);
      chk("R1", "strobes", 32'(strobes()), 0);
   endtask

   task automatic t_single_reader();
      step("R2", E_RD, 1, 0, S_FETCH | S_ALLOC, 5'd4);
      step("R4", E_MDATA, 0, 0, S_DATA | S_EXCL | S_FREE, 5'd8);
      chk("R4", "rsp_dst", 32'(cap_rsp), 32'h2);
      step("R5", E_RD, 2, 0, S_RCY, 5'd8);
      step("R5", E_REPL, 0, 1, S_RCY, 5'd8);
      step("R5", E_XUNBLK, 1, 0, S_NONE, 5'd3);
      chk("R5", "sharers", 32'(o_sharers), 32'h2);
      chk("R5", "owner", 32'(o_owner), 1);
      step("R9", E_WB, 3, 0, S_NONE, 5'd3);
      chk("R9", "sharers kept", 32'(o_sharers), 32'h2);
      step("R9", E_WB, 1, 0, S_WBA, 5'd2);
      chk("R9", "rsp_dst", 32'(cap_rsp), 32'h2);
      chk("R9", "sharers", 32'(o_sharers), 0);
   endtask

   task automatic t_modified_and_shared();
      step("R12", E_IRD, 0, 0, S_DATA, 5'd1);
      chk("R12", "sharers", 32'(o_sharers), 32'h1);
      step("R10", E_RD, 2, 0, S_DATA, 5'd1);
      chk("R10", "sharers", 32'(o_sharers), 32'h5);
      step("R10", E_UPG, 0, 0, S_INV | S_UPGA, 5'd7);
      chk("R10", "req_dst", 32'(cap_req), 32'h4);
      chk("R10", "rsp_dst", 32'(cap_rsp), 32'h1);
      step("R5", E_XUNBLK, 0, 0, S_NONE, 5'd3);
   endtask

   task automatic t_fwd_data_first();
      step("R6", E_RD, 3, 0, S_FWD, 5'd9);
      chk("R6", "req_dst", 32'(cap_req), 32'h1);
      step("R6", E_LDATA, 0, 0, S_NONE, 5'd11);
      step("R6", E_UNBLK, 3, 0, S_NONE, 5'd1);
      chk("R6", "sharers", 32'(o_sharers), 32'h9);
   endtask

   task automatic t_evict_shared_clean();
      step("R7", E_REPL, 0, 0, S_INV | S_ALLOC, 5'd12);
      chk("R7", "req_dst", 32'(cap_req), 32'h9);
      step("R7", E_LACK, 0, 0, S_NONE, 5'd12);
      step("R7", E_LACK, 3, 0, S_FREE, 5'd0);
   endtask

   task automatic t_multi_reader();
      step("R2", E_IRD, 2, 0, S_FETCH | S_ALLOC, 5'd5);
      step("R3", E_RD, 3, 0, S_NONE, 5'd5);
      step("R3", E_XRD, 1, 0, S_RCY, 5'd5);
      step("R4", E_MDATA, 0, 0, S_DATA | S_FREE, 5'd1);
      chk("R4", "rsp_dst", 32'(cap_rsp), 32'hC);
      step("R10", E_XRD, 1, 0, S_DATA | S_INV, 5'd7);
      chk("R10", "rsp_dst", 32'(cap_rsp), 32'h2);
      chk("R10", "req_dst", 32'(cap_req), 32'hC);
      step("R5", E_XUNBLK, 1, 0, S_NONE, 5'd3);
      step("R8", E_REPL, 0, 1, S_INV | S_ALLOC, 5'd14);
      chk("R8", "req_dst", 32'(cap_req), 32'h2);
      step("R8", E_LDATA, 1, 1, S_MWB, 5'd16);
      step("R7", E_MACK, 0, 0, S_FREE, 5'd0);
   endtask

   task automatic t_excl_fill();
      step("R2", E_XRD, 0, 0, S_FETCH | S_ALLOC, 5'd6);
      step("R4", E_MDATA, 0, 0, S_DATA | S_FREE, 5'd8);
      chk("R4", "rsp_dst", 32'(cap_rsp), 32'h1);
      step("R5", E_XUNBLK, 0, 0, S_NONE, 5'd3);
      step("R8", E_REPL, 0, 0, S_INV | S_ALLOC, 5'd15);
      step("R8", E_LDATA, 0, 0, S_FREE, 5'd0);
   endtask

   task automatic t_fwd_unblock_first();
      step("R2", E_XRD, 0, 0, S_FETCH | S_ALLOC, 5'd6);
      step("R4", E_MDATA, 0, 0, S_DATA | S_FREE, 5'd8);
      step("R5", E_XUNBLK, 0, 0, S_NONE, 5'd3);
      step("R6", E_IRD, 1, 0, S_FWD, 5'd9);
      step("R6", E_UNBLK, 1, 0, S_NONE, 5'd10);
      step("R6", E_RD, 2, 0, S_RCY, 5'd10);
      step("R6", E_LDATA, 0, 0, S_NONE, 5'd1);
      chk("R6", "sharers", 32'(o_sharers), 32'h3);
      step("R7", E_REPL, 0, 1, S_INV | S_ALLOC, 5'd13);
      step("R7", E_LACK, 0, 0, S_NONE, 5'd13);
      step("R7", E_LACK, 1, 0, S_MWB, 5'd16);
      step("R7", E_RD, 2, 0, S_RCY, 5'd16);
      step("R7", E_MACK, 0, 0, S_FREE, 5'd0);
   endtask

   task automatic t_modified_paths();
      step("R2", E_XRD, 2, 0, S_FETCH | S_ALLOC, 5'd6);
      step("R4", E_MDATA, 0, 0, S_DATA | S_FREE, 5'd8);
      step("R5", E_XUNBLK, 2, 0, S_NONE, 5'd3);
      step("R9", E_WB, 2, 0, S_WBA, 5'd2);
      step("R12", E_RD, 1, 0, S_DATA | S_EXCL, 5'd8);
      chk("R12", "rsp_dst", 32'(cap_rsp), 32'h2);
      step("R5", E_XUNBLK, 1, 0, S_NONE, 5'd3);
      step("R9", E_WB, 1, 0, S_WBA, 5'd2);
      step("R12", E_REPL, 0, 0, S_MWB | S_ALLOC, 5'd16);
      step("R12", E_MACK, 0, 0, S_FREE, 5'd0);
   endtask

   task automatic t_idle_and_illegal();
      @(negedge clk); #1;
      chk("R11", "idle strobes", 32'(strobes()), 0);
      step("R11", 4'd13, 0, 0, S_NONE, 5'd0);
      chk("R11", "err", 32'(o_err), 1);
      step("R11", E_MACK, 0, 0, S_NONE, 5'd0);
      repeat (2) @(negedge clk);
      chk("R11", "err sticky", 32'(o_err), 1);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      t_reset();
      t_single_reader();
      t_modified_and_shared();
      t_fwd_data_first();
      t_evict_shared_clean();
      t_multi_reader();
      t_excl_fill();
      t_fwd_unblock_first();
      t_modified_paths();
      t_idle_and_illegal();
      summary();
   end
endmodule